// File: doc/BRIEF.md
# Local Interrupt Source Conditioning Entry

This block turns one local interrupt source into a delivery request. The source may be an asynchronous input pin or an internal event line; it is synchronised, corrected for polarity, then detected either as an edge or as a level. Whether the source may raise a request, and what that request carries, is set by one 32-bit entry register. The register holds the vector, the delivery mode, the input polarity, the trigger mode and a mask bit. It also shows two live flags that software can read but not write: a request-pending flag and a level-in-service flag.

A downstream acceptor sees `req_valid` together with the vector and the mode. It drops the request by pulsing `req_ack`. For a level-triggered source in Fixed mode, that acknowledge also sets the in-service flag. The flag then blocks any new request from the source until `eoi_in` is pulsed. A masked entry discards activity on its source and does not hold it for later. Software writes the entry through a byte-enabled port, so the mask can be flipped without rewriting the vector or the mode.

Top module: `pin_irq_entry`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (only the mask bit, bit 16, set) and `req_valid` is 0.
- R2: The entry layout is: vector in bits 7:0; delivery mode in bits 10:8 (0 Fixed, 2 SMI, 4 NMI, 7 ExtINT); polarity in bit 13 (1 = active-low); trigger in bit 15 (1 = level); mask in bit 16. Bits 11 and 31:17 read as 0.
- R3: Bit 12 reads as the pending flag and bit 14 reads as the in-service flag. Software writes to these two bits have no effect.
- R4: `reg_be[0]` writes the vector, `reg_be[1]` writes bits 15:8, and `reg_be[2]` writes the mask. Bytes that are not enabled keep their value.
- R5: In edge mode, one inactive-to-active transition of the polarity-corrected source raises exactly one request. With the default two-stage synchroniser, `req_valid` is visible after the third rising clock edge following the input change.
- R6: With bit 13 set, a low source is the active state. Changing the polarity so that the current input becomes active counts as a transition.
- R7: While the mask bit is set, no request is raised. An edge that arrives while masked is lost, and clearing the mask later does not raise a request for it.
- R8: `req_valid` stays high until a cycle with `req_ack` high, and is low in the cycle after that. `req_vector` and `req_mode` show the entry's vector and mode fields.
- R9: In level mode, a request is raised while the source is active, unmasked and the in-service flag is clear. Acknowledging a Fixed-mode level request sets the in-service flag, and no new request is raised while the flag is set.
- R10: `eoi_in` clears the in-service flag. If the level source is still active, a new request follows.
- R11: Acknowledging a level request whose mode is not Fixed leaves the in-service flag clear.
- R12: A source edge that arrives while a request is pending is dropped and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 1 | Raw interrupt source |
| reg_we | input | 1 | Entry write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current entry contents including live flags |
| eoi_in | input | 1 | End-of-interrupt pulse, clears in-service flag |
| req_valid | output | 1 | Delivery request pending |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_ack | input | 1 | Acceptor takes the pending request |

## Verification
Directed sequences cover the following cases:
- An isolated rising edge, used to show that exactly one request appears and that it arrives at the stated cycle.
- A polarity flip applied while the input is idle, used to show that a polarity-induced transition counts as an edge.
- Edges while masked, and edges while a request is pending, used to show that both kinds are dropped rather than queued.
- A held level in Fixed mode and a held level in NMI mode, used to show when the in-service flag gates a new request.

A long random run then toggles the source, acknowledge, end-of-interrupt and byte-masked writes together. Every cycle is compared with a requirement-derived model. This run exposes priority mistakes between acknowledge, end-of-interrupt and writes that land in the same cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   localparam int unsigned ENTRY_W   = 32;
   localparam int unsigned VECTOR_W  = 8;
   localparam int unsigned MODE_W    = 3;
   localparam int unsigned MODE_LSB  = 8;
   localparam int unsigned PEND_BIT  = 12;
   localparam int unsigned POL_BIT   = 13;
   localparam int unsigned INSVC_BIT = 14;
   localparam int unsigned TRIG_BIT  = 15;
   localparam int unsigned MASK_BIT  = 16;

   localparam logic [MODE_W-1:0] DM_FIXED  = 3'd0;
   localparam logic [MODE_W-1:0] DM_SMI    = 3'd2;
   localparam logic [MODE_W-1:0] DM_NMI    = 3'd4;
   localparam logic [MODE_W-1:0] DM_EXTINT = 3'd7;

   typedef struct packed {
      logic                masked;
      logic                trig_level;
      logic                pol_low;
      logic [MODE_W-1:0]   mode;
      logic [VECTOR_W-1:0] vector;
   } entry_cfg_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   localparam int unsigned LAST = STAGES - 1;

   logic [LAST:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pin_irq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[LAST-1:0], d_in};
   end

   assign q_out = chain_q[LAST];
endmodule

// File: rtl/pin_irq_cfg_reg.sv
module pin_irq_cfg_reg
   import pin_irq_pkg::*;
#(
   parameter int unsigned BYTES        = ENTRY_W / 8,
   parameter bit          RESET_MASKED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [BYTES-1:0]   be,
   input  logic [ENTRY_W-1:0] wdata,
   output entry_cfg_t         cfg
);
   localparam int unsigned LANE_VEC  = 0;
   localparam int unsigned LANE_CTL  = MODE_LSB / 8;
   localparam int unsigned LANE_MASK = MASK_BIT / 8;

   logic [BYTES-1:0] lane_wr;

   for (genvar l = 0; l < BYTES; l++) begin : g_lane
      assign lane_wr[l] = we & be[l];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.vector <= '0;
      end else if (lane_wr[LANE_VEC]) begin
         cfg.vector <= wdata[VECTOR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.mode       <= DM_FIXED;
         cfg.pol_low    <= 1'b0;
         cfg.trig_level <= 1'b0;
      end else if (lane_wr[LANE_CTL]) begin
         cfg.mode       <= wdata[MODE_LSB +: MODE_W];
         cfg.pol_low    <= wdata[POL_BIT];
         cfg.trig_level <= wdata[TRIG_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.masked <= RESET_MASKED;
      end else if (lane_wr[LANE_MASK]) begin
         cfg.masked <= wdata[MASK_BIT];
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[ENTRY_W-1:MASK_BIT+1], wdata[INSVC_BIT],
                           wdata[PEND_BIT], wdata[MODE_LSB+MODE_W],
                           lane_wr[BYTES-1]};
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sense,
   input  logic pol_low,
   input  logic trig_level,
   input  logic masked,
   input  logic is_fixed,
   input  logic ack,
   input  logic eoi,
   output logic pend,
   output logic in_svc
);
   logic active;
   logic active_q;
   logic edge_hit;
   logic level_hit;
   logic raise;
   logic taken;

   assign active    = sense ^ pol_low;
   assign edge_hit  = active & ~active_q;
   assign level_hit = active & ~in_svc;
   assign raise     = ~pend & ~masked & (trig_level ? level_hit : edge_hit);
   assign taken     = pend & ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend <= 1'b0;
      else if (taken) pend <= 1'b0;
      else if (raise) pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               in_svc <= 1'b0;
      else if (taken && trig_level && is_fixed) in_svc <= 1'b1;
      else if (eoi)                             in_svc <= 1'b0;
   end
endmodule

// File: rtl/pin_irq_entry.sv
module pin_irq_entry
   import pin_irq_pkg::*;
#(
   parameter bit          ASYNC_SRC    = 1'b1,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          RESET_MASKED = 1'b1,
   parameter int unsigned REG_W        = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                src_in,
   input  logic                reg_we,
   input  logic [REG_W/8-1:0]  reg_be,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic                eoi_in,
   output logic                req_valid,
   output logic [VECTOR_W-1:0] req_vector,
   output logic [MODE_W-1:0]   req_mode,
   input  logic                req_ack
);
   localparam int unsigned BYTES = REG_W / 8;

   if (REG_W != ENTRY_W) begin : g_bad_width
      $error("pin_irq_entry: REG_W must equal the entry width");
   end

   entry_cfg_t cfg;
   logic       sense;
   logic       pend;
   logic       in_svc;

   if (ASYNC_SRC) begin : g_sync
      pin_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_in  (src_in),
         .q_out (sense)
      );
   end else begin : g_direct
      assign sense = src_in;
   end

   pin_irq_cfg_reg #(.BYTES(BYTES), .RESET_MASKED(RESET_MASKED)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .be    (reg_be),
      .wdata (reg_wdata),
      .cfg   (cfg)
   );

   pin_irq_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .sense      (sense),
      .pol_low    (cfg.pol_low),
      .trig_level (cfg.trig_level),
      .masked     (cfg.masked),
      .is_fixed   (cfg.mode == DM_FIXED),
      .ack        (req_ack),
      .eoi        (eoi_in),
      .pend       (pend),
      .in_svc     (in_svc)
   );

   always_comb begin
      reg_rdata                     = '0;
      reg_rdata[VECTOR_W-1:0]       = cfg.vector;
      reg_rdata[MODE_LSB +: MODE_W] = cfg.mode;
      reg_rdata[PEND_BIT]           = pend;
      reg_rdata[POL_BIT]            = cfg.pol_low;
      reg_rdata[INSVC_BIT]          = in_svc;
      reg_rdata[TRIG_BIT]           = cfg.trig_level;
      reg_rdata[MASK_BIT]           = cfg.masked;
   end

   assign req_valid  = pend;
   assign req_vector = cfg.vector;
   assign req_mode   = cfg.mode;
endmodule

// File: rtl/pin_irq_entry_chk.sv
module pin_irq_entry_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [3:0]  reg_be,
   input logic [31:0] reg_rdata,
   input logic        eoi_in,
   input logic        req_valid,
   input logic        req_ack
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid);

   // R8
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid);

   // R7
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[16] && !req_valid |=> !req_valid);

   // R9
   insvc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[14] && reg_rdata[15] && !req_valid |=> !req_valid);

   // R3
   insvc_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[14] && !(req_valid && req_ack) |=> !reg_rdata[14]);

   // R10
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_in && !req_ack |=> !reg_rdata[14]);

   // R4
   vec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_be[0]) |=> $stable(reg_rdata[7:0]));
endmodule

bind pin_irq_entry pin_irq_entry_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_be    (reg_be),
   .reg_rdata (reg_rdata),
   .eoi_in    (eoi_in),
   .req_valid (req_valid),
   .req_ack   (req_ack)
);

// File: tb/pin_irq_entry_tb.sv
module pin_irq_entry_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_in = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eoi_in = 1'b0;
   logic        req_valid;
   logic [7:0]  req_vector;
   logic [2:0]  req_mode;
   logic        req_ack = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit rnd_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_irq_entry u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eoi_in(eoi_in), .req_valid(req_valid), .req_vector(req_vector),
      .req_mode(req_mode), .req_ack(req_ack)
   );

   // requirement-derived model, updated on the same edges
   logic       m_s1, m_s2, m_prev, m_pend, m_isv, m_pol, m_trig, m_mask;
   logic [7:0] m_vec;
   logic [2:0] m_mode;

   function automatic logic [31:0] model_word();
      return {15'd0, m_mask, m_trig, m_isv, m_pol, m_pend, 1'b0, m_mode, m_vec};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_pend <= 0; m_isv <= 0;
         m_pol <= 0; m_trig <= 0; m_mask <= 1; m_vec <= 0; m_mode <= 0;
      end else begin
         logic act, hit;
         act = m_s2 ^ m_pol;
         hit = m_trig ? (act && !m_isv) : (act && !m_prev);
         if (m_pend && req_ack) m_pend <= 0;
         else if (!m_pend && !m_mask && hit) m_pend <= 1;
         if (m_pend && req_ack && m_trig && m_mode == 3'd0) m_isv <= 1;
         else if (eoi_in) m_isv <= 0;
         m_prev <= act; m_s2 <= m_s1; m_s1 <= src_in;
         if (reg_we && reg_be[0]) m_vec <= reg_wdata[7:0];
         if (reg_we && reg_be[1]) begin
            m_mode <= reg_wdata[10:8]; m_pol <= reg_wdata[13]; m_trig <= reg_wdata[15];
         end
         if (reg_we && reg_be[2]) m_mask <= reg_wdata[16];
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [3:0] be, logic [31:0] d);
      reg_we = 1; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_we = 0; reg_be = '0;
   endtask

   task automatic ack();
      req_ack = 1; @(negedge clk); req_ack = 0;
   endtask

   task automatic eoi();
      eoi_in = 1; @(negedge clk); eoi_in = 0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   // random-phase comparison against the model
   always @(negedge clk) begin
      if (rnd_on) begin
         check("R2 R3 entry word", reg_rdata, model_word());
         check("R8 req_valid", {31'd0, req_valid}, {31'd0, m_pend});
         if (req_valid) check("R8 req fields", {21'd0, req_mode, req_vector},
                              {21'd0, m_mode, m_vec});
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      cycles(3);
      // R1 reset state
      check("R1 reset word", reg_rdata, 32'h0001_0000);
      check("R1 reset valid", {31'd0, req_valid}, 32'd0);
      rst_n = 1;
      cycles(1);

      // R2 R3 full write: bits 12/14 and reserved ignored
      wr(4'hF, 32'hFFFF_FFFF);
      check("R2 R3 full write", reg_rdata, 32'h0001_A7FF);
      // R4 partial writes
      wr(4'b0011, 32'h0000_0030);
      check("R4 low bytes only", reg_rdata, 32'h0001_0030);
      wr(4'b0100, 32'h0000_0000);
      check("R4 unmask keeps vector", reg_rdata, 32'h0000_0030);

      // R5 single edge, latency
      src_in = 1;
      cycles(2);
      check("R5 not yet", {31'd0, req_valid}, 32'd0);
      cycles(1);
      check("R5 raised", {31'd0, req_valid}, 32'd1);
      check("R8 vector", {24'd0, req_vector}, 32'h30);
      check("R3 pend bit", {31'd0, reg_rdata[12]}, 32'd1);
      cycles(5);
      check("R8 held", {31'd0, req_valid}, 32'd1);
      ack();
      check("R8 dropped", {31'd0, req_valid}, 32'd0);
      cycles(5);
      check("R5 exactly one", {31'd0, req_valid}, 32'd0);
      src_in = 0;
      cycles(4);

      // R6 polarity flip makes low input active
      wr(4'b0010, 32'h0000_2000);
      cycles(4);
      check("R6 flip edge", {31'd0, req_valid}, 32'd1);
      ack();
      src_in = 1; cycles(5);
      check("R6 inactive rise", {31'd0, req_valid}, 32'd0);
      src_in = 0; cycles(3);
      check("R6 active low", {31'd0, req_valid}, 32'd1);
      ack();

      // R7 mask drops
      wr(4'b0100, 32'h0001_0000);
      src_in = 1; cycles(5);
      src_in = 0; cycles(5);
      check("R7 masked", {31'd0, req_valid}, 32'd0);
      wr(4'b0100, 32'h0000_0000);
      cycles(5);
      check("R7 not replayed", {31'd0, req_valid}, 32'd0);

      // R12 edge during pending dropped
      src_in = 1; cycles(4);
      src_in = 0; cycles(4);
      check("R12 first", {31'd0, req_valid}, 32'd1);
      src_in = 1; cycles(4);
      src_in = 0; cycles(4);
      ack();
      cycles(5);
      check("R12 no queue", {31'd0, req_valid}, 32'd0);

      // R9 level Fixed
      src_in = 1;
      wr(4'b0011, 32'h0000_8055);
      cycles(4);
      check("R9 level raise", {31'd0, req_valid}, 32'd1);
      ack();
      check("R9 insvc set", {31'd0, reg_rdata[14]}, 32'd1);
      cycles(5);
      check("R9 blocked", {31'd0, req_valid}, 32'd0);
      eoi();
      check("R10 insvc clear", {31'd0, reg_rdata[14]}, 32'd0);
      cycles(1);
      check("R10 re-raise", {31'd0, req_valid}, 32'd1);
      ack();
      src_in = 0;
      cycles(3);
      eoi();
      cycles(5);
      check("R10 idle after eoi", {16'd0, reg_rdata[14], req_valid, 14'd0},
            32'd0);

      // R11 level NMI
      wr(4'b0010, 32'h0000_8400);
      src_in = 1; cycles(4);
      check("R11 nmi raise", {29'd0, req_mode}, 32'd4);
      ack();
      check("R11 no insvc", {31'd0, reg_rdata[14]}, 32'd0);
      cycles(1);
      check("R11 re-raise", {31'd0, req_valid}, 32'd1);
      ack();
      src_in = 0;
      cycles(4);
      if (req_valid) ack();
      cycles(2);

      // R3 write to read-only bits
      wr(4'b0010, 32'h0000_5000);
      check("R3 ro bits", reg_rdata, 32'h0000_0055);

      // random phase against model
      cycles(4);
      rnd_on = 1;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(7) == 0) src_in = ~src_in;
         req_ack   = ($urandom_range(3) == 0);
         eoi_in    = ($urandom_range(15) == 0);
         reg_we    = ($urandom_range(23) == 0);
         reg_be    = 4'($urandom);
         reg_wdata = $urandom;
         @(negedge clk);
      end
      rnd_on = 0;
      finish_run();
   end
endmodule